// File: doc/BRIEF.md
# Relocatable Instruction Cache with Line Fill

This block holds 512 bytes of program code for a small coprocessor, split into 32 lines of 16 bytes, each line with its own valid bit. The cache covers a 512-byte window of the program address space that starts at a movable base register. A fetch presents a 16-bit program counter and a 7-bit program bank. The block answers with the opcode byte and the number of coprocessor cycles the fetch costs.

A fetch inside the window that finds its line valid is served from the array. A fetch that finds its line invalid first fills the whole line from an external byte memory, one byte per clock, and then serves the byte. A fetch outside the window reads the external memory directly.

A host port reads and writes the array through a byte window. Writing the last byte of a line through that port marks the line valid, so a host can preload code. Writing the program bank and stopping the coprocessor each discard the cached contents.

Top module: `prog_cache`

## Requirements
- R1: The offset is `fetch_pc - base` modulo 2^16. A fetch is a cache access only when the offset is below 512. Any other fetch drives `mem_addr = {fetch_bank, fetch_pc}` in its accept cycle and returns `mem_rdata` one clock later, costing 5 cycles when `clk_sel` is 1 and 6 when it is 0.
- R2: A fetch that hits returns array byte [offset] one clock after accept, costing 1 cycle when `clk_sel` is 1 and 2 when it is 0.
- R3: A fetch to an invalid line holds `busy` for 16 clocks. On clock i (0..15) it drives `mem_addr = {fetch_bank, base + (offset & 0x1F0) + i}`, then marks the line valid and returns the byte two clocks after `busy` falls. The reported cost is 16×5+1 = 81 when `clk_sel` is 1, or 16×6+2 = 98 when it is 0.
- R4: The line index is offset bits 8:4. A fill validates only its own line.
- R5: For host addresses 0x100–0x2FF, a write stores to array byte (base + addr − 0x100) & 0x1FF, and a read returns that byte on `host_rdata` one clock after `host_rd`. A read outside the window returns 0, and a write outside the window changes no byte and no valid bit.
- R6: A host write whose mapped array index has low four bits 0xF sets the valid bit of that index's line. Later fetches to that line hit and return the bytes the host wrote.
- R7: A `bank_wr` pulse clears all 32 valid bits.
- R8: When `run` falls from 1 to 0, the base resets to 0 and all valid bits clear. This takes priority over a base load in the same cycle.
- R9: After reset, `busy` and `fetch_done` are 0, the base is 0 and no line is valid. The array contents are left undefined.
- R10: `fetch_done` is a single-clock pulse and never rises while `busy` is high. A request must be held until `fetch_done`, and a new one is accepted only while `fetch_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 1 | 1 selects the fast cycle costs |
| run | input | 1 | Coprocessor run flag; a falling edge flushes the cache |
| base_load | input | 1 | Load the window base |
| base_value | input | 16 | New window base |
| bank_wr | input | 1 | Program bank written; invalidates all lines |
| fetch_req | input | 1 | Fetch request, held until done |
| fetch_pc | input | 16 | Program counter |
| fetch_bank | input | 7 | Program bank |
| fetch_done | output | 1 | Fetch result valid (one clock) |
| fetch_byte | output | 8 | Fetched opcode byte |
| fetch_cycles | output | 8 | Cost of the fetch in coprocessor cycles |
| busy | output | 1 | Line fill in progress |
| mem_rd | output | 1 | External read strobe |
| mem_addr | output | 23 | External byte address {bank, address} |
| mem_rdata | input | 8 | External read data, same clock |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 10 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one clock after the strobe |

## Verification
The embedded properties check four things on every clock. Fill addresses advance by one while `busy` is high. A completed fetch always reports one of the six legal costs. `fetch_done` is a lone pulse that never overlaps `busy`. Bank writes and run falls leave the cache empty and the base at zero.

Other behaviour needs the bench scenarios, run against its behavioural model. These cover the window edges at offsets 511, 512 and wrap-around, line-by-line validity, and host preloading through the last byte of a line. They also cover a relocated base for both the host map and fetches, and whether the returned bytes are correct.

// File: rtl/prog_cache.sv
module prog_cache #(
  parameter int LINES      = 32,
  parameter int LINE_BYTES = 16,
  parameter int PC_W       = 16,
  parameter int BANK_W     = 7,
  parameter int HOST_W     = 10,
  parameter int HOST_LO    = 'h100,
  parameter int FAST_MEM   = 5,
  parameter int SLOW_MEM   = 6,
  parameter int FAST_HIT   = 1,
  parameter int SLOW_HIT   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clk_sel,
  input  logic                   run,
  input  logic                   base_load,
  input  logic [PC_W-1:0]        base_value,
  input  logic                   bank_wr,
  input  logic                   fetch_req,
  input  logic [PC_W-1:0]        fetch_pc,
  input  logic [BANK_W-1:0]      fetch_bank,
  output logic                   fetch_done,
  output logic [7:0]             fetch_byte,
  output logic [7:0]             fetch_cycles,
  output logic                   busy,
  output logic                   mem_rd,
  output logic [BANK_W+PC_W-1:0] mem_addr,
  input  logic [7:0]             mem_rdata,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic [HOST_W-1:0]      host_addr,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata
);
  localparam int DEPTH = LINES * LINE_BYTES;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int LN_W  = $clog2(LINES);

  logic [7:0]        arr [DEPTH];
  logic [LINES-1:0]  valid_q;
  logic [PC_W-1:0]   base_q;
  logic              run_q, filling_q, fill_pend_q, done_q;
  logic [LN_W-1:0]   fill_line_q;
  logic [OFS_W-1:0]  fill_cnt_q;
  logic [7:0]        data_q, cost_q, host_q;

  wire [PC_W-1:0]   off      = fetch_pc - base_q;
  wire              in_win   = off < PC_W'(DEPTH);
  wire [IDX_W-1:0]  idx      = off[IDX_W-1:0];
  wire [LN_W-1:0]   line     = off[IDX_W-1:OFS_W];
  wire              accept   = fetch_req && !filling_q && !done_q;
  wire              hit      = in_win && valid_q[line];
  wire [IDX_W-1:0]  fill_idx = {fill_line_q, fill_cnt_q};
  wire [PC_W-1:0]   fill_pc  = base_q + PC_W'(fill_idx);
  wire              run_fall = run_q && !run;

  wire [7:0] mem_cost  = clk_sel ? 8'(FAST_MEM) : 8'(SLOW_MEM);
  wire [7:0] hit_cost  = clk_sel ? 8'(FAST_HIT) : 8'(SLOW_HIT);
  wire [7:0] fill_cost = clk_sel ? 8'(FAST_MEM * LINE_BYTES) : 8'(SLOW_MEM * LINE_BYTES);

  wire [HOST_W-1:0] host_off = host_addr - HOST_W'(HOST_LO);
  wire              host_in  = (host_addr >= HOST_W'(HOST_LO)) && (host_off < HOST_W'(DEPTH));
  wire [IDX_W-1:0]  host_idx = base_q[IDX_W-1:0] + host_off[IDX_W-1:0];
  wire              host_st  = host_wr && host_in;

  assign mem_addr     = filling_q ? {fetch_bank, fill_pc} : {fetch_bank, fetch_pc};
  assign mem_rd       = filling_q || (accept && !in_win);
  assign busy         = filling_q;
  assign fetch_done   = done_q;
  assign fetch_byte   = data_q;
  assign fetch_cycles = cost_q;
  assign host_rdata   = host_q;

  always_ff @(posedge clk) begin
    if (filling_q) arr[fill_idx] <= mem_rdata;
    if (host_st && !(filling_q && host_idx == fill_idx)) arr[host_idx] <= host_wdata;
    if (host_rd) host_q <= host_in ? arr[host_idx] : 8'h00;
    if (accept && (hit || !in_win)) data_q <= in_win ? arr[idx] : mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q     <= '0;
      base_q      <= '0;
      run_q       <= 1'b0;
      filling_q   <= 1'b0;
      fill_pend_q <= 1'b0;
      done_q      <= 1'b0;
      fill_line_q <= '0;
      fill_cnt_q  <= '0;
      cost_q      <= '0;
    end else begin
      run_q  <= run;
      done_q <= 1'b0;
      if (run_fall)       base_q <= '0;
      else if (base_load) base_q <= base_value;
      if (filling_q) begin
        fill_cnt_q <= fill_cnt_q + 1'b1;
        if (&fill_cnt_q) begin
          filling_q            <= 1'b0;
          valid_q[fill_line_q] <= 1'b1;
        end
      end else if (accept) begin
        if (!in_win) begin
          done_q <= 1'b1;
          cost_q <= mem_cost;
        end else if (hit) begin
          done_q      <= 1'b1;
          cost_q      <= hit_cost + (fill_pend_q ? fill_cost : 8'd0);
          fill_pend_q <= 1'b0;
        end else begin
          filling_q   <= 1'b1;
          fill_pend_q <= 1'b1;
          fill_line_q <= line;
          fill_cnt_q  <= '0;
        end
      end
      if (bank_wr || run_fall) valid_q <= '0;
      if (host_st && (&host_idx[OFS_W-1:0])) valid_q[host_idx[IDX_W-1:OFS_W]] <= 1'b1;
    end
  end

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fetch_done);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> !fetch_done);
  assert_fill_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fill_cnt_q != '0) |-> mem_addr[PC_W-1:0] == $past(mem_addr[PC_W-1:0]) + 1'b1);
  assert_cost_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |-> (fetch_cycles == 8'(FAST_HIT) || fetch_cycles == 8'(SLOW_HIT) ||
                    fetch_cycles == 8'(FAST_MEM) || fetch_cycles == 8'(SLOW_MEM) ||
                    fetch_cycles == 8'(FAST_MEM * LINE_BYTES + FAST_HIT) ||
                    fetch_cycles == 8'(SLOW_MEM * LINE_BYTES + SLOW_HIT)));
  assert_bank_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr && !host_wr) |=> valid_q == '0);
  assert_run_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !run && !host_wr) |=> (base_q == '0 && valid_q == '0));
endmodule

// File: tb/prog_cache_tb.sv
module prog_cache_tb;
  logic clk = 0, rst_n = 0, clk_sel = 1, run = 0, base_load = 0, bank_wr = 0;
  logic [15:0] base_value = 0, fetch_pc = 0;
  logic fetch_req = 0, host_wr = 0, host_rd = 0;
  logic [6:0] fetch_bank = 7'h01;
  logic [9:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic fetch_done, busy, mem_rd;
  logic [7:0] fetch_byte, fetch_cycles, host_rdata, mem_rdata;
  logic [22:0] mem_addr;

  int checks = 0, fails = 0;
  logic [7:0] cache_m [512];
  bit valid_m [32];
  int base_m = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] mb(input logic [22:0] a);
    return 8'((int'(a[7:0]) * 7) + (int'(a[15:8]) * 13) + (int'(a[22:16]) * 29) + 3);
  endfunction
  assign mem_rdata = mb(mem_addr);

  prog_cache u_dut (.clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .run(run),
    .base_load(base_load), .base_value(base_value), .bank_wr(bank_wr),
    .fetch_req(fetch_req), .fetch_pc(fetch_pc), .fetch_bank(fetch_bank),
    .fetch_done(fetch_done), .fetch_byte(fetch_byte), .fetch_cycles(fetch_cycles),
    .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic fetch(input logic [15:0] pc, input string req);
    int off = int'(16'(pc - 16'(base_m)));
    int ln = off >> 4;
    int exp_busy = 0, exp_cost, cyc = 0, seen = 0;
    logic [7:0] exp_byte;
    if (off < 512) begin
      if (!valid_m[ln]) begin
        exp_busy = 16;
        for (int i = 0; i < 16; i++)
          cache_m[ln*16+i] = mb({fetch_bank, 16'(base_m + ln*16 + i)});
        valid_m[ln] = 1;
        exp_cost = clk_sel ? 81 : 98;
      end else exp_cost = clk_sel ? 1 : 2;
      exp_byte = cache_m[off];
    end else begin
      exp_byte = mb({fetch_bank, pc});
      exp_cost = clk_sel ? 5 : 6;
    end
    @(negedge clk); fetch_req = 1; fetch_pc = pc;
    forever begin
      @(negedge clk); cyc++;
      if (busy) begin
        check(mem_addr == {fetch_bank, 16'(base_m + ln*16 + seen)}, req, "fill address",
              int'(mem_addr), int'({fetch_bank, 16'(base_m + ln*16 + seen)}));
        seen++;
      end
      if (fetch_done || cyc > 40) break;
    end
    fetch_req = 0;
    check(fetch_done, req, "done seen", int'(fetch_done), 1);
    check(fetch_byte == exp_byte, req, "byte", int'(fetch_byte), int'(exp_byte));
    check(int'(fetch_cycles) == exp_cost, req, "cost", int'(fetch_cycles), exp_cost);
    check(seen == exp_busy, req, "busy clocks", seen, exp_busy);
    check(cyc == (exp_busy != 0 ? exp_busy + 2 : 1), req, "latency", cyc, exp_busy != 0 ? exp_busy + 2 : 1);
    @(negedge clk);
    check(!fetch_done, "R10", "done pulse width", int'(fetch_done), 0);
  endtask

  task automatic hwrite(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
    if (a >= 10'h100 && a <= 10'h2FF) begin
      int ix = (base_m + int'(a) - 'h100) & 'h1FF;
      cache_m[ix] = d;
      if ((ix & 'hF) == 'hF) valid_m[ix >> 4] = 1;
    end
  endtask

  task automatic hread(input logic [9:0] a, input string req);
    logic [7:0] e = 0;
    if (a >= 10'h100 && a <= 10'h2FF) e = cache_m[(base_m + int'(a) - 'h100) & 'h1FF];
    @(negedge clk); host_rd = 1; host_addr = a;
    @(negedge clk); host_rd = 0;
    check(host_rdata == e, req, "host read", int'(host_rdata), int'(e));
  endtask

  task automatic load_base(input logic [15:0] b);
    @(negedge clk); base_load = 1; base_value = b;
    @(negedge clk); base_load = 0; base_m = int'(b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !fetch_done, "R9", "reset outputs", int'({busy, fetch_done}), 0);
    rst_n = 1; run = 1;
    fetch(16'h0004, "R9");
    load_base(16'h8000);
    fetch(16'h8003, "R3");
    fetch(16'h800A, "R2");
    clk_sel = 0;
    fetch(16'h8013, "R4");
    fetch(16'h8011, "R2");
    fetch(16'h7FFF, "R1");
    fetch(16'h8200, "R1");
    fetch(16'h81FF, "R1");
    clk_sel = 1;
    fetch(16'h9234, "R1");
    fetch(16'h81F0, "R4");
    hread(10'h103, "R5");
    hread(10'h2FF, "R5");
    hread(10'h300, "R5");
    for (int i = 0; i < 16; i++) hwrite(10'(10'h140 + i), 8'(8'hA0 + i));
    fetch(16'h8047, "R6");
    fetch(16'h804F, "R6");
    hwrite(10'h06F, 8'h55);
    fetch(16'h8160, "R5");
    load_base(16'h9010);
    hwrite(10'h100, 8'h3C);
    hread(10'h100, "R5");
    hwrite(10'h2FF, 8'h77);
    hread(10'h2FF, "R5");
    fetch(16'h9010, "R6");
    fetch(16'h9025, "R4");
    @(negedge clk); bank_wr = 1; fetch_bank = 7'h22;
    @(negedge clk); bank_wr = 0;
    for (int i = 0; i < 32; i++) valid_m[i] = 0;
    fetch(16'h9025, "R7");
    @(negedge clk); run = 0; base_load = 1; base_value = 16'h4444;
    @(negedge clk); base_load = 0;
    base_m = 0;
    for (int i = 0; i < 32; i++) valid_m[i] = 0;
    fetch(16'h9025, "R8");
    fetch(16'h0005, "R8");
    summary();
  end
endmodule